// File: doc/BRIEF.md
# Per-Channel Hit Timestamper with Wilkinson Conversion

This block is the digital back end of one auto-triggered photodetector channel. A discriminator output arrives asynchronously; the block synchronises it, finds its leading edge and, when the channel can take a hit, stamps it with the value of a free-running coarse counter. It then starts two ramp conversions in the storage slot it has allocated. Each conversion is a counter on the conversion clock that runs until a ramp comparator changes level. One conversion gives charge and the other gives fine time.

The channel has two storage slots, each with its own pair of converters. Once a hit is accepted, the channel is blind for a fixed dead time. A hit that lands in the dead time, or that finds both slots occupied, is discarded and added to a lost-hit count. Records that have finished converting leave on a valid/ready port in the order their hits were accepted. A chip holds sixteen instances of the block. The shared discriminator threshold and all analogue parts live outside it.

Top module: `hts_channel`

## Requirements
- R1: While reset is held and after it is released, `rec_valid_o` is 0 and `lost_cnt_o` is 0 until a hit is processed.
- R2: A hit is taken only on a low-to-high change of the synchronised `hit_i`. Keeping `hit_i` high produces exactly one record and does not raise the lost count.
- R3: The coarse field is the value of a counter that increments on every clock and wraps modulo 2^COARSE_W (26 bits by default). Two accepted hits whose `hit_i` rising edges are D clocks apart carry coarse values that differ by D modulo 2^COARSE_W.
- R4: The charge field equals N when `qcmp_i[s]` of the allocated slot s changes level after the N-th clock following acceptance. The converter counts with 10-bit resolution.
- R5: The fine field follows the same rule as R4 using `tcmp_i[s]`, independently of the charge conversion.
- R6: A conversion whose comparator has not changed level when its count holds 1023 stops at 1023 and sets its saturation flag: record bit 0 for charge, bit 1 for fine. A change seen exactly at count 1023 gives 1023 with the flag clear.
- R7: With two records pending and not yet read, a further hit is dropped and `lost_cnt_o` increases by one.
- R8: After an accepted hit, a rising edge detected within DEAD_CYC clocks (800 by default, about 5 µs at 160 MHz) is dropped and counted as lost. One detected DEAD_CYC+1 clocks later is accepted.
- R9: Slots are allocated round-robin starting at slot 0. Records leave in acceptance order, with the slot index in the top field of the record.
- R10: The record is {slot, coarse, fine[9:0], charge[9:0], flags[1:0]}, most significant field first. While `rec_valid_o` is high and `rec_ready_i` is low, `rec_valid_o` stays high and `rec_o` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 1 | Discriminator output, asynchronous |
| qcmp_i | input | NSLOT | Charge ramp comparator, one per slot |
| tcmp_i | input | NSLOT | Fine-time ramp comparator, one per slot |
| rec_valid_o | output | 1 | Oldest record ready |
| rec_ready_i | input | 1 | Downstream accepts the record |
| rec_o | output | SLOT_W+COARSE_W+2*CNT_W+2 | Packed hit record |
| lost_cnt_o | output | LOST_W | Saturating count of dropped hits |

## Verification
The bench places a second hit exactly DEAD_CYC and DEAD_CYC+1 clocks after a first one. An off-by-one dead timer therefore either loses a good hit or accepts one that should have been dropped. It also drives comparator changes just before and exactly at count 1023. A design that tests saturation before the level change would set the flag in the wrong case. With the output stalled, it fills both slots and fires a third hit, then reads the records back in order. Mixing up slot order, or letting a full slot be overwritten, shows up as wrong coarse spacing, a wrong slot index or a missing lost count. Finally, it forces a coarse wrap and holds `hit_i` high, which exposes level-triggered capture.

// File: rtl/hts_pkg.sv
`timescale 1ns/1ps
package hts_pkg;
  typedef enum logic [1:0] {
    SL_FREE = 2'd0,
    SL_CONV = 2'd1,
    SL_DONE = 2'd2
  } slot_state_e;

  localparam int FLG_W   = 2;
  localparam int FLG_QSAT = 0;
  localparam int FLG_TSAT = 1;
endpackage

// File: rtl/hts_edge_sync.sv
`timescale 1ns/1ps
module hts_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/hts_wilk_conv.sv
`timescale 1ns/1ps
module hts_wilk_conv #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             run_q, ref_q, sat_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ref_q <= 1'b0;
      sat_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      ref_q <= cmp_i;
      sat_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      // comparator change wins over saturation in the same cycle
      if (cmp_i != ref_q) begin
        run_q <= 1'b0;
      end else if (cnt_q == CNT_MAX) begin
        run_q <= 1'b0;
        sat_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = run_q;
  assign cnt_o  = cnt_q;
  assign sat_o  = sat_q;
endmodule

// File: rtl/hts_slot.sv
`timescale 1ns/1ps
module hts_slot
  import hts_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int COARSE_W = 26
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alloc_i,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic                qcmp_i,
  input  logic                tcmp_i,
  input  logic                free_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [COARSE_W-1:0] coarse_o,
  output logic [CNT_W-1:0]    charge_o,
  output logic [CNT_W-1:0]    fine_o,
  output logic [FLG_W-1:0]    flags_o
);
  slot_state_e        state_q;
  logic [COARSE_W-1:0] coarse_q;
  logic               q_busy, t_busy, q_sat, t_sat;

  hts_wilk_conv #(.CNT_W(CNT_W)) u_qconv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(alloc_i),
    .cmp_i  (qcmp_i),
    .busy_o (q_busy),
    .cnt_o  (charge_o),
    .sat_o  (q_sat)
  );

  hts_wilk_conv #(.CNT_W(CNT_W)) u_tconv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(alloc_i),
    .cmp_i  (tcmp_i),
    .busy_o (t_busy),
    .cnt_o  (fine_o),
    .sat_o  (t_sat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SL_FREE;
      coarse_q <= '0;
    end else begin
      case (state_q)
        SL_FREE: if (alloc_i) begin
          state_q  <= SL_CONV;
          coarse_q <= coarse_i;
        end
        SL_CONV: if (!q_busy && !t_busy) state_q <= SL_DONE;
        SL_DONE: if (free_i) state_q <= SL_FREE;
        default: state_q <= SL_FREE;
      endcase
    end
  end

  assign busy_o   = (state_q != SL_FREE);
  assign done_o   = (state_q == SL_DONE);
  assign coarse_o = coarse_q;
  assign flags_o  = {t_sat, q_sat};
endmodule

// File: rtl/hts_dead_timer.sv
`timescale 1ns/1ps
module hts_dead_timer #(
  parameter int DEAD_CYC = 800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic dead_o
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DLOAD = DW'(DEAD_CYC);

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= DLOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign dead_o = (cnt_q != '0);
endmodule

// File: rtl/hts_channel.sv
`timescale 1ns/1ps
module hts_channel
  import hts_pkg::*;
#(
  parameter int NSLOT       = 2,
  parameter int CNT_W       = 10,
  parameter int COARSE_W    = 26,
  parameter int DEAD_CYC    = 800,
  parameter int LOST_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SLOT_W     = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int REC_W      = SLOT_W + COARSE_W + 2*CNT_W + FLG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [NSLOT-1:0]  qcmp_i,
  input  logic [NSLOT-1:0]  tcmp_i,
  output logic              rec_valid_o,
  input  logic              rec_ready_i,
  output logic [REC_W-1:0]  rec_o,
  output logic [LOST_W-1:0] lost_cnt_o
);
  localparam logic [SLOT_W-1:0] PTR_LAST = SLOT_W'(NSLOT - 1);

  logic                hit_rise, dead, full, hit_accept, rec_fire;
  logic [COARSE_W-1:0] coarse_q;
  logic [SLOT_W-1:0]   wr_ptr_q, rd_ptr_q;
  logic [LOST_W-1:0]   lost_q;

  logic [NSLOT-1:0]    s_busy, s_done, s_alloc, s_free;
  logic [COARSE_W-1:0] s_coarse [NSLOT];
  logic [CNT_W-1:0]    s_charge [NSLOT];
  logic [CNT_W-1:0]    s_fine   [NSLOT];
  logic [FLG_W-1:0]    s_flags  [NSLOT];

  hts_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(hit_i),
    .rise_o (hit_rise)
  );

  hts_dead_timer #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(hit_accept),
    .dead_o (dead)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coarse_q <= '0;
    else         coarse_q <= coarse_q + 1'b1;
  end

  // round-robin allocation keeps acceptance order equal to slot order
  assign full       = s_busy[wr_ptr_q];
  assign hit_accept = hit_rise & ~dead & ~full;
  assign rec_valid_o = s_done[rd_ptr_q];
  assign rec_fire   = rec_valid_o & rec_ready_i;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign s_alloc[g] = hit_accept & (wr_ptr_q == SLOT_W'(g));
    assign s_free[g]  = rec_fire   & (rd_ptr_q == SLOT_W'(g));

    hts_slot #(.CNT_W(CNT_W), .COARSE_W(COARSE_W)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .alloc_i (s_alloc[g]),
      .coarse_i(coarse_q),
      .qcmp_i  (qcmp_i[g]),
      .tcmp_i  (tcmp_i[g]),
      .free_i  (s_free[g]),
      .busy_o  (s_busy[g]),
      .done_o  (s_done[g]),
      .coarse_o(s_coarse[g]),
      .charge_o(s_charge[g]),
      .fine_o  (s_fine[g]),
      .flags_o (s_flags[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (hit_accept) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (rec_fire)   rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      lost_q <= '0;
    else if (hit_rise && (dead || full) && (lost_q != '1))
      lost_q <= lost_q + 1'b1;
  end

  assign lost_cnt_o = lost_q;
  assign rec_o = {rd_ptr_q, s_coarse[rd_ptr_q], s_fine[rd_ptr_q],
                  s_charge[rd_ptr_q], s_flags[rd_ptr_q]};
endmodule

// File: rtl/hts_channel_chk.sv
`timescale 1ns/1ps
module hts_channel_chk #(
  parameter int CNT_W    = 10,
  parameter int DEAD_CYC = 800,
  parameter int LOST_W   = 16,
  parameter int REC_W    = 49
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hit_accept,
  input logic              rec_valid_o,
  input logic              rec_ready_i,
  input logic [REC_W-1:0]  rec_o,
  input logic [LOST_W-1:0] lost_cnt_o
);
  localparam int GW = $clog2(DEAD_CYC + 2) + 1;
  localparam logic [GW-1:0] GAP_SAT = GW'(DEAD_CYC + 1);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (hit_accept) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != GAP_SAT) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_idle_in_reset: assert (!rec_valid_o && lost_cnt_o == '0);
  end

  a_r8_dead_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_accept && seen_q) |-> (gap_q >= GW'(DEAD_CYC)));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && !rec_ready_i) |=> (rec_valid_o && $stable(rec_o)));

  a_r7_lost_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (lost_cnt_o == $past(lost_cnt_o) ||
              lost_cnt_o == $past(lost_cnt_o) + 1'b1));

  a_r6_qsat_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_o[0]) |-> (rec_o[CNT_W+1:2] == CMAX));

  a_r6_tsat_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_o[1]) |-> (rec_o[2*CNT_W+1:CNT_W+2] == CMAX));
endmodule

bind hts_channel hts_channel_chk #(
  .CNT_W(CNT_W), .DEAD_CYC(DEAD_CYC), .LOST_W(LOST_W), .REC_W(REC_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hit_accept (hit_accept),
  .rec_valid_o(rec_valid_o),
  .rec_ready_i(rec_ready_i),
  .rec_o      (rec_o),
  .lost_cnt_o (lost_cnt_o)
);

// File: tb/hts_channel_test.sv
`timescale 1ns/1ps
module hts_channel_test;
  localparam int NSLOT = 2;
  localparam int CNT_W = 10;
  localparam int CW    = 12;
  localparam int DEAD  = 800;
  localparam int LW    = 16;
  localparam int SW    = 1;
  localparam int RW    = SW + CW + 2*CNT_W + 2;
  localparam int CMOD  = 1 << CW;

  logic clk = 1'b0, rst_n = 1'b0, hit = 1'b0, ready = 1'b0;
  logic [NSLOT-1:0] qcmp = '0, tcmp = '0;
  logic valid;
  logic [RW-1:0] rec;
  logic [LW-1:0] lost;

  int cyc = 0, checks = 0, errors = 0, exp_wr = 0, exp_lost = 0;
  bit done = 1'b0;

  hts_channel #(.NSLOT(NSLOT), .CNT_W(CNT_W), .COARSE_W(CW), .DEAD_CYC(DEAD),
                .LOST_W(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .qcmp_i(qcmp), .tcmp_i(tcmp),
    .rec_valid_o(valid), .rec_ready_i(ready), .rec_o(rec), .lost_cnt_o(lost));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int f_slot(logic [RW-1:0] r);   return int'(r[RW-1]); endfunction
  function automatic int f_coarse(logic [RW-1:0] r); return int'(r[RW-2 -: CW]); endfunction
  function automatic int f_fine(logic [RW-1:0] r);   return int'(r[2*CNT_W+1 -: CNT_W]); endfunction
  function automatic int f_charge(logic [RW-1:0] r); return int'(r[CNT_W+1 -: CNT_W]); endfunction
  function automatic int f_flags(logic [RW-1:0] r);  return int'(r[1:0]); endfunction

  task automatic wait_tag(int t);
    @(negedge clk);
    while (cyc < t) @(negedge clk);
  endtask

  // Called at a negedge. Drives a rising edge; toggles the comparators of the
  // expected slot after nq / nt clocks past acceptance (0 = never).
  task automatic fire(bit accept, int nq, int nt, bit hold, output int tag);
    int s = exp_wr;
    int m = (nq > nt) ? nq : nt;
    hit = 1'b1;
    tag = cyc;
    @(posedge clk);
    @(negedge clk);
    if (!hold) hit = 1'b0;
    @(posedge clk);
    @(posedge clk);
    if (accept) begin
      exp_wr = (exp_wr + 1) % NSLOT;
      for (int k = 1; k <= m; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (k == nq) qcmp[s] = ~qcmp[s];
        if (k == nt) tcmp[s] = ~tcmp[s];
      end
    end else begin
      exp_lost++;
    end
  endtask

  task automatic pop(output logic [RW-1:0] r);
    int n = 0;
    @(negedge clk);
    while (!valid && n < 3000) begin @(negedge clk); n++; end
    check(valid, "R9 record valid", valid, 1);
    r = rec;
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
  endtask

  task automatic t_reset;
    check(!valid, "R1 valid after reset", valid, 0);
    check(lost == 0, "R1 lost after reset", lost, 0);
  endtask

  task automatic t_basic;
    int ta, tb;
    logic [RW-1:0] ra, rb;
    wait_tag(cyc + 1);
    fire(1, 37, 120, 0, ta);
    pop(ra);
    check(f_charge(ra) == 37, "R4 charge 37", f_charge(ra), 37);
    check(f_fine(ra) == 120, "R5 fine 120", f_fine(ra), 120);
    check(f_flags(ra) == 0, "R6 no flags", f_flags(ra), 0);
    check(f_slot(ra) == 0, "R9 first slot", f_slot(ra), 0);
    wait_tag(ta + 900);
    fire(1, 500, 3, 0, tb);
    pop(rb);
    check(f_charge(rb) == 500, "R4 charge 500", f_charge(rb), 500);
    check(f_fine(rb) == 3, "R5 fine 3", f_fine(rb), 3);
    check(f_slot(rb) == 1, "R9 second slot", f_slot(rb), 1);
    check(((f_coarse(rb) - f_coarse(ra) + CMOD) % CMOD) == (tb - ta) % CMOD,
          "R3 coarse spacing", (f_coarse(rb) - f_coarse(ra) + CMOD) % CMOD, (tb - ta) % CMOD);
  endtask

  task automatic t_saturate;
    int t;
    logic [RW-1:0] r;
    wait_tag(cyc + 900);
    fire(1, 0, 10, 0, t);
    pop(r);
    check(f_charge(r) == 1023, "R6 charge saturated", f_charge(r), 1023);
    check(f_flags(r) == 1, "R6 charge sat flag", f_flags(r), 1);
    check(f_fine(r) == 10, "R5 fine beside sat", f_fine(r), 10);
    wait_tag(cyc + 900);
    fire(1, 1023, 1022, 0, t);
    pop(r);
    check(f_charge(r) == 1023, "R6 change at 1023", f_charge(r), 1023);
    check(f_flags(r) == 0, "R6 no flag at 1023 change", f_flags(r), 0);
    check(f_fine(r) == 1022, "R5 fine 1022", f_fine(r), 1022);
  endtask

  task automatic t_level_hold;
    int t;
    logic [RW-1:0] r;
    wait_tag(cyc + 900);
    fire(1, 5, 6, 1, t);
    pop(r);
    check(f_charge(r) == 5, "R2 held hit converts", f_charge(r), 5);
    wait_tag(t + 2000);
    check(!valid, "R2 no second record while held", valid, 0);
    check(lost == LW'(exp_lost), "R2 held level not lost", lost, exp_lost);
    hit = 1'b0;
  endtask

  task automatic t_dead;
    int ta, tb;
    logic [RW-1:0] r;
    wait_tag(cyc + 900);
    fire(1, 0, 0, 0, ta);
    wait_tag(ta + DEAD);
    fire(0, 0, 0, 0, tb);
    repeat (3) @(negedge clk);
    check(lost == LW'(exp_lost), "R8 hit at DEAD_CYC dropped", lost, exp_lost);
    pop(r);
    check(f_flags(r) == 3, "R6 both saturated", f_flags(r), 3);
    repeat (1200) @(negedge clk);
    check(!valid, "R8 dropped hit left no record", valid, 0);
  endtask

  task automatic t_full;
    int ta, tb, tc;
    logic [RW-1:0] ra, rb;
    logic [RW-1:0] snap;
    wait_tag(cyc + 900);
    fire(1, 0, 0, 0, ta);
    wait_tag(ta + DEAD + 1);
    fire(1, 0, 0, 0, tb);
    wait_tag(tb + DEAD + 1);
    fire(0, 0, 0, 0, tc);
    repeat (3) @(negedge clk);
    check(lost == LW'(exp_lost), "R7 third hit dropped when full", lost, exp_lost);
    check(valid, "R10 valid while stalled", valid, 1);
    snap = rec;
    repeat (20) @(negedge clk);
    check(valid && rec == snap, "R10 record held under stall", valid, 1);
    pop(ra);
    pop(rb);
    check(f_slot(ra) == 0 && f_slot(rb) == 1, "R9 slot order",
          f_slot(ra) * 2 + f_slot(rb), 1);
    check(((f_coarse(rb) - f_coarse(ra) + CMOD) % CMOD) == DEAD + 1,
          "R8 hit at DEAD_CYC+1 accepted", (f_coarse(rb) - f_coarse(ra) + CMOD) % CMOD, DEAD + 1);
    repeat (5) @(negedge clk);
    check(!valid, "R7 no third record", valid, 0);
  endtask

  task automatic t_wrap;
    int ta, tb, ca, d, expc;
    logic [RW-1:0] ra, rb;
    wait_tag(cyc + 900);
    fire(1, 2, 2, 0, ta);
    pop(ra);
    ca = f_coarse(ra);
    d = (CMOD - ca) + 900;
    wait_tag(ta + d);
    fire(1, 2, 2, 0, tb);
    pop(rb);
    expc = (ca + (tb - ta)) % CMOD;
    check(f_coarse(rb) == expc, "R3 coarse wraps", f_coarse(rb), expc);
    check(f_coarse(rb) < ca, "R3 wrapped below first", f_coarse(rb), ca);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_saturate();
    t_level_hold();
    t_dead();
    t_full();
    t_wrap();
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 150000) @(negedge clk);
    if (!done) check(1'b0, "watchdog", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule